// File: doc/BRIEF.md
# Secure and Privileged Register Access Filter

This block sits between a simple register bus and a small peripheral register file. For every access it decides, bit by bit, whether a write may land and whether a read may show the stored value. The decision combines three inputs. The first is a global trust-zone enable pin. The second is a security configuration register that marks each of five function groups as secure. The third is a privilege configuration register with two bits: one makes secure bits privileged-only, and one makes non-secure bits privileged-only.

A denied access is never reported as an error. Its write is dropped and its read returns zero, and it still gets an ordinary response. The response of every request arrives exactly one cycle after the request.

The five function groups are low-power mode, wake-up lines, voltage monitoring, battery mode and I/O pull configuration. They are numbered 0 to 4, in that order. The peripheral registers are modelled as a generic array of data registers.

The control path is a two-state machine. In state `S_IDLE` no response is pending. In state `S_ACK` a response is being presented. Its transitions are:
- `S_IDLE`→`S_ACK` on a request.
- `S_ACK`→`S_ACK` on a back-to-back request.
- `S_ACK`→`S_IDLE` when there is no request.
- `S_IDLE`→`S_IDLE` when idle.

Top module: `secpriv_filter`

## Requirements
- R1: After reset, every register holds zero and `rsp_valid_o` is low.
- R2: Every cycle with `req_valid_i` high is followed, in the next cycle, by `rsp_valid_o` high. A cycle without a request is followed by `rsp_valid_o` low. A write response carries zero data.
- R3: Bit b of data register a (addresses 2 to 7) belongs to group (a+b) mod 5. When the trust-zone enable is 1 and bit g of the security register (address 0) is set, group g is secure. A non-secure access to a bit of a secure group reads zero and does not change it.
- R4: With the trust-zone enable at 0, address 0 reads zero and ignores writes. Every data bit is treated as non-secure, and every access is treated as non-secure.
- R5: Address 1 holds the secure-privilege bit (bit 0) and the non-secure-privilege bit (bit 1). Any access may read them. Bit 0 is written only by a secure privileged access while the trust-zone enable is 1. Bit 1 is written by any privileged access. Unprivileged writes are ignored, and bits 2 and above read zero.
- R6: With bit 0 of address 1 set, bits of secure groups are reachable only by secure privileged accesses. Address 0 and address 1 stay readable by unprivileged accesses. Writes to address 0 then also need privilege.
- R7: With bit 1 of address 1 set, bits of non-secure groups are reachable only by privileged accesses. The one exception is that the status register (address 7) stays readable by unprivileged accesses. Unprivileged writes to it are still ignored.
- R8: Masking is per bit. A write changes only the allowed bits and leaves the others at their old value. A read returns the stored value ANDed with the allowed mask.
- R9: With the trust-zone enable at 1, only a secure access may write bits 4:0 of address 0. Bits 7:5 of address 0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tz_en_i | input | 1 | Global trust-zone enable |
| req_valid_i | input | 1 | Request strobe, one request per cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW (3) | Register address |
| req_wdata_i | input | DW (8) | Write data |
| req_secure_i | input | 1 | Request is secure |
| req_priv_i | input | 1 | Request is privileged |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | DW (8) | Masked read data, zero for writes |

## Verification
A request driven before a rising edge is captured on that edge. Its response, with `rsp_valid_o` and the masked data, is due one cycle later. The bench drives on the falling edge and checks the response on the next falling edge, which is half a cycle after the state machine entered `S_ACK`. A write or configuration change takes effect on the capturing edge, so it first shows in the request that follows, even back to back. The bench model updates its register copy only after the response check, and it computes each expected mask from the configuration as it stood before that request. Idle cycles are checked for a low `rsp_valid_o` one cycle after the idle slot.

// File: rtl/secpriv_pkg.sv
package secpriv_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int GRP_N      = 5;
    localparam int ADDR_SEC   = 0;
    localparam int ADDR_PRIV  = 1;
    localparam int FIRST_DATA = 2;
    localparam int PB_SPRIV   = 0;
    localparam int PB_NSPRIV  = 1;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } fsm_e;
endpackage

// File: rtl/secpriv_mask.sv
module secpriv_mask
    import secpriv_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int NGRP = GRP_N
) (
    input  logic          tz_en_i,
    input  logic [DW-1:0] sec_cfg_i,
    input  logic [DW-1:0] priv_cfg_i,
    input  logic [AW-1:0] addr_i,
    input  logic          write_i,
    input  logic          secure_i,
    input  logic          priv_i,
    output logic [DW-1:0] allow_o
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [AW-1:0] STATUS_ADDR = AW'((1 << AW) - 1);

    function automatic logic [IW-1:0] grp_of(input logic [AW-1:0] a, input int b);
        int s;
        s = (int'(a) + b) % NGRP;
        return IW'(s);
    endfunction

    logic          eff_sec;
    logic          spriv;
    logic          nspriv;
    logic [DW-1:0] grp_sec;

    assign eff_sec = secure_i & tz_en_i;
    assign spriv   = priv_cfg_i[PB_SPRIV];
    assign nspriv  = priv_cfg_i[PB_NSPRIV];

    always_comb begin
        for (int b = 0; b < DW; b++) begin
            grp_sec[b] = tz_en_i & sec_cfg_i[grp_of(addr_i, b)];
        end
    end

    always_comb begin
        allow_o = '0;
        if (addr_i == AW'(ADDR_SEC)) begin
            for (int b = 0; b < DW; b++) begin
                if (b < NGRP) begin
                    allow_o[b] = tz_en_i & (!write_i | (eff_sec & (!spriv | priv_i)));
                end
            end
        end else if (addr_i == AW'(ADDR_PRIV)) begin
            allow_o[PB_SPRIV]  = !write_i | (eff_sec & priv_i);
            allow_o[PB_NSPRIV] = !write_i | priv_i;
        end else begin
            for (int b = 0; b < DW; b++) begin
                if (grp_sec[b]) begin
                    allow_o[b] = eff_sec & (!spriv | priv_i);
                end else begin
                    allow_o[b] = !nspriv | priv_i | (!write_i && addr_i == STATUS_ADDR);
                end
            end
        end
    end
endmodule

// File: rtl/secpriv_cfg.sv
module secpriv_cfg
    import secpriv_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_sec_i,
    input  logic          wr_priv_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] mask_i,
    output logic [DW-1:0] sec_cfg_o,
    output logic [DW-1:0] priv_cfg_o
);
    logic [DW-1:0] sec_q;
    logic [DW-1:0] priv_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sec_q <= '0;
        end else if (wr_sec_i) begin
            sec_q <= (sec_q & ~mask_i) | (wdata_i & mask_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            priv_q <= '0;
        end else if (wr_priv_i) begin
            priv_q <= (priv_q & ~mask_i) | (wdata_i & mask_i);
        end
    end

    assign sec_cfg_o  = sec_q;
    assign priv_cfg_o = priv_q;
endmodule

// File: rtl/secpriv_regarray.sv
module secpriv_regarray
    import secpriv_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] mask_i,
    output logic [DW-1:0] rdata_o
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs_q [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        if (r >= FIRST_DATA) begin : g_data
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    regs_q[r] <= '0;
                end else if (wr_en_i && addr_i == AW'(r)) begin
                    regs_q[r] <= (regs_q[r] & ~mask_i) | (wdata_i & mask_i);
                end
            end
        end else begin : g_hole
            always_ff @(posedge clk_i) begin
                regs_q[r] <= '0;
            end
        end
    end

    assign rdata_o = regs_q[addr_i];
endmodule

// File: rtl/secpriv_filter.sv
module secpriv_filter
    import secpriv_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int NGRP = GRP_N
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tz_en_i,
    input  logic          req_valid_i,
    input  logic          req_write_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic          req_secure_i,
    input  logic          req_priv_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_rdata_o
);
    fsm_e          state_q;
    fsm_e          state_d;
    logic [DW-1:0] allow_w;
    logic [DW-1:0] sec_cfg_w;
    logic [DW-1:0] priv_cfg_w;
    logic [DW-1:0] arr_rdata_w;
    logic [DW-1:0] rd_raw;
    logic [DW-1:0] rdata_q;
    logic          wr_go;
    logic          wr_sec;
    logic          wr_priv;

    assign wr_go   = req_valid_i & req_write_i;
    assign wr_sec  = wr_go & (req_addr_i == AW'(ADDR_SEC));
    assign wr_priv = wr_go & (req_addr_i == AW'(ADDR_PRIV));

    secpriv_mask #(.DW(DW), .AW(AW), .NGRP(NGRP)) u_mask (
        .tz_en_i    (tz_en_i),
        .sec_cfg_i  (sec_cfg_w),
        .priv_cfg_i (priv_cfg_w),
        .addr_i     (req_addr_i),
        .write_i    (req_write_i),
        .secure_i   (req_secure_i),
        .priv_i     (req_priv_i),
        .allow_o    (allow_w)
    );

    secpriv_cfg #(.DW(DW)) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_sec_i   (wr_sec),
        .wr_priv_i  (wr_priv),
        .wdata_i    (req_wdata_i),
        .mask_i     (allow_w),
        .sec_cfg_o  (sec_cfg_w),
        .priv_cfg_o (priv_cfg_w)
    );

    secpriv_regarray #(.DW(DW), .AW(AW)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_go),
        .addr_i  (req_addr_i),
        .wdata_i (req_wdata_i),
        .mask_i  (allow_w),
        .rdata_o (arr_rdata_w)
    );

    always_comb begin
        if (req_addr_i == AW'(ADDR_SEC)) begin
            rd_raw = sec_cfg_w;
        end else if (req_addr_i == AW'(ADDR_PRIV)) begin
            rd_raw = priv_cfg_w;
        end else begin
            rd_raw = arr_rdata_w;
        end
    end

    // State register plus captured read data
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (req_valid_i && !req_write_i) ? (rd_raw & allow_w) : '0;
        end
    end

    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE:  state_d = req_valid_i ? S_ACK : S_IDLE;
            S_ACK:   state_d = req_valid_i ? S_ACK : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        rsp_valid_o = 1'b0;
        rsp_rdata_o = '0;
        unique case (state_q)
            S_IDLE: begin
                rsp_valid_o = 1'b0;
                rsp_rdata_o = '0;
            end
            S_ACK: begin
                rsp_valid_o = 1'b1;
                rsp_rdata_o = rdata_q;
            end
            default: begin
                rsp_valid_o = 1'b0;
                rsp_rdata_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/secpriv_filter_chk.sv
module secpriv_filter_chk #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          tz_en_i,
    input logic          req_valid_i,
    input logic          req_write_i,
    input logic [AW-1:0] req_addr_i,
    input logic          req_secure_i,
    input logic          req_priv_i,
    input logic          rsp_valid_o,
    input logic [DW-1:0] rsp_rdata_o,
    input logic [DW-1:0] sec_cfg_i,
    input logic [DW-1:0] priv_cfg_i
);
    a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    a_r2_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o);

    a_r2_write_rsp_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i) |=> (rsp_rdata_o == '0));

    a_r4_tz_off_sec_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_write_i && req_addr_i == '0 && !tz_en_i) |=> (rsp_rdata_o == '0));

    a_r4_tz_off_sec_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && req_addr_i == '0 && !tz_en_i) |=> $stable(sec_cfg_i));

    a_r5_unpriv_priv_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && req_addr_i == AW'(1) && !req_priv_i) |=> $stable(priv_cfg_i));

    a_r9_nonsecure_sec_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && req_addr_i == '0 && !req_secure_i) |=> $stable(sec_cfg_i));
endmodule

bind secpriv_filter secpriv_filter_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tz_en_i      (tz_en_i),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_addr_i   (req_addr_i),
    .req_secure_i (req_secure_i),
    .req_priv_i   (req_priv_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_rdata_o  (rsp_rdata_o),
    .sec_cfg_i    (sec_cfg_w),
    .priv_cfg_i   (priv_cfg_w)
);

// File: tb/sim_secpriv_filter.sv
module sim_secpriv_filter;
    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int NREG = 1 << AW;
    localparam int NGRP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tz_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_secure = 1'b0;
    logic          req_priv = 1'b0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;

    int n_checks = 0;
    int n_bad = 0;
    logic [DW-1:0] mdl [NREG];

    always #2 clk = ~clk;

    secpriv_filter #(.DW(DW), .AW(AW), .NGRP(NGRP)) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tz_en_i      (tz_en),
        .req_valid_i  (req_valid),
        .req_write_i  (req_write),
        .req_addr_i   (req_addr),
        .req_wdata_i  (req_wdata),
        .req_secure_i (req_secure),
        .req_priv_i   (req_priv),
        .rsp_valid_o  (rsp_valid),
        .rsp_rdata_o  (rsp_rdata)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Allowed-bit mask derived from the requirements
    function automatic logic [DW-1:0] exp_mask(input int a, input bit w, input bit s, input bit p);
        logic [DW-1:0] m;
        bit es, sp, nsp, gs;
        m   = '0;
        es  = s & tz_en;
        sp  = mdl[1][0];
        nsp = mdl[1][1];
        if (a == 0) begin
            for (int b = 0; b < NGRP; b++) m[b] = tz_en & (!w | (es & (!sp | p)));
        end else if (a == 1) begin
            m[0] = !w | (es & p);
            m[1] = !w | p;
        end else begin
            for (int b = 0; b < DW; b++) begin
                gs = tz_en & mdl[0][(a + b) % NGRP];
                if (gs) m[b] = es & (!sp | p);
                else    m[b] = !nsp | p | (!w && a == NREG - 1);
            end
        end
        return m;
    endfunction

    task automatic txn(input string tag, input bit w, input int a, input logic [DW-1:0] d,
                       input bit s, input bit p);
        logic [DW-1:0] m;
        m = exp_mask(a, w, s, p);
        req_valid  = 1'b1;
        req_write  = w;
        req_addr   = AW'(a);
        req_wdata  = d;
        req_secure = s;
        req_priv   = p;
        @(negedge clk);
        check({tag, " rsp_valid"}, DW'(rsp_valid), DW'(1));
        check({tag, " rdata"}, rsp_rdata, w ? '0 : (mdl[a] & m));
        if (w) mdl[a] = (mdl[a] & ~m) | (d & m);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 idle rsp_valid", DW'(rsp_valid), DW'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rsp_valid", DW'(rsp_valid), DW'(0));
        tz_en = 1'b1;
        for (int a = 0; a < NREG; a++) txn("R1 reset value", 1'b0, a, '0, 1'b1, 1'b1);
        idle();

        // R4: trust-zone disabled
        tz_en = 1'b0;
        txn("R4 sec write tz off", 1'b1, 0, 8'h1F, 1'b1, 1'b1);
        txn("R4 sec read tz off", 1'b0, 0, '0, 1'b1, 1'b1);
        txn("R4 data write ns", 1'b1, 2, 8'hFF, 1'b0, 1'b0);
        txn("R4 data read ns", 1'b0, 2, '0, 1'b0, 1'b0);
        check("R4 data all bits", mdl[2], 8'hFF);

        // R9 / R3: security configuration
        tz_en = 1'b1;
        txn("R9 ns write sec", 1'b1, 0, 8'hFF, 1'b0, 1'b1);
        txn("R9 read sec", 1'b0, 0, '0, 1'b0, 1'b0);
        check("R9 sec unchanged", mdl[0], 8'h00);
        txn("R9 s write sec", 1'b1, 0, 8'hE1, 1'b1, 1'b0);
        check("R9 upper bits dropped", mdl[0], 8'h01);
        txn("R3 ns read masks group0", 1'b0, 2, '0, 1'b0, 1'b1);
        txn("R3 ns write ignored", 1'b1, 2, 8'h00, 1'b0, 1'b1);
        check("R3 group0 bit kept", mdl[2], 8'h08);
        txn("R8 s read full", 1'b0, 2, '0, 1'b1, 1'b0);
        idle();

        // R5: privilege configuration
        txn("R5 unpriv write", 1'b1, 1, 8'hFF, 1'b1, 1'b0);
        txn("R5 ns priv write", 1'b1, 1, 8'hFF, 1'b0, 1'b1);
        check("R5 only ns bit", mdl[1], 8'h02);
        txn("R5 s priv write", 1'b1, 1, 8'h01, 1'b1, 1'b1);
        txn("R5 unpriv read", 1'b0, 1, '0, 1'b0, 1'b0);
        check("R5 value", mdl[1], 8'h01);

        // R6: secure-privilege set
        txn("R6 unpriv s read data", 1'b0, 2, '0, 1'b1, 1'b0);
        txn("R6 unpriv read sec", 1'b0, 0, '0, 1'b0, 1'b0);
        txn("R6 unpriv s write sec", 1'b1, 0, 8'h00, 1'b1, 1'b0);
        check("R6 sec kept", mdl[0], 8'h01);

        // R7: non-secure-privilege set
        txn("R7 set nspriv", 1'b1, 1, 8'h03, 1'b1, 1'b1);
        txn("R7 priv write status", 1'b1, 7, 8'hA5, 1'b1, 1'b1);
        txn("R7 unpriv read status", 1'b0, 7, '0, 1'b0, 1'b0);
        txn("R7 unpriv write status", 1'b1, 7, 8'h00, 1'b0, 1'b0);
        txn("R7 unpriv read data", 1'b0, 2, '0, 1'b0, 1'b0);
        idle();

        // R8: randomized mix against the model
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(9) == 0) tz_en = ~tz_en;
            txn("R8 random", 1'($urandom_range(1)), int'($urandom_range(NREG - 1)),
                DW'($urandom), 1'($urandom_range(1)), 1'($urandom_range(1)));
            if ($urandom_range(3) == 0) idle();
        end
        idle();

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule